// File: doc/BRIEF.md
# Event-Driven Output Set/Clear Resolver

This block owns a bank of output pins and turns a vector of single-cycle event strobes into pin changes. Each pin has two masks over the event vector: one selects the events that drive the pin high, the other selects the events that drive it low. When the timer beside it counts down, a per-pin swap mode can exchange the two roles. This lets one set of events produce a centre-aligned waveform in both counting directions.

Set and clear can both hit one pin in the same cycle. A per-pin policy then decides the outcome: hold, drive high, drive low or toggle. The block also records the collision in a sticky flag, and the flag can raise an interrupt. While the timer is halted, events have no effect and software can write the pin values directly.

All pin values, flags and the interrupt are registered. A change in the inputs sampled at one rising edge shows at the outputs right after that edge.

Top module: `event_output_resolver`

## Requirements
- R1: After a synchronous reset, all pins, all conflict flags and the conflict interrupt are low.
- R2: While not halted, an event selected only by a pin's high mask (`set_mask_i[n*NUM_EV +: NUM_EV]`) drives that pin to 1 at the next edge. An event selected only by its low mask (`clr_mask_i`, same layout) drives the pin to 0.
- R3: A pin whose masks select no active event in a cycle keeps its previous value.
- R4: Swap code 1 (`swap_mode_i[2n +: 2]` = 1) exchanges the high and low roles of pin n while `down_lo_i` is 1.
- R5: Swap code 2 exchanges the roles while `down_hi_i` is 1. Codes 0 and 3 never exchange them.
- R6: When both masks of pin n hit in one cycle, the resolution code `res_mode_i[2n +: 2]` picks the result: 0 holds, 1 drives 1, 2 drives 0, 3 inverts.
- R7: While a pin's roles are exchanged, resolution codes 1 and 2 exchange meaning: 1 drives 0 and 2 drives 1.
- R8: A collision on pin n while not halted sets flag n, and the flag stays set. A 1 on `conf_clr_i[n]` clears it. A new collision in the same cycle as the clear leaves the flag set.
- R9: `conf_irq_o` is 1 exactly when some flag is set and its bit in `conf_en_i` was 1 in the cycle that produced that flag value.
- R10: While `halted_i` is 1, events change neither pins nor flags, and `out_wr_i` loads `out_wdata_i` into the pins at the next edge. While not halted, `out_wr_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NUM_EV | Event strobes for this cycle |
| set_mask_i | input | NUM_OUT*NUM_EV | Per-pin high masks, pin n at bits n*NUM_EV upward |
| clr_mask_i | input | NUM_OUT*NUM_EV | Per-pin low masks, same layout |
| swap_mode_i | input | 2*NUM_OUT | Per-pin swap code |
| res_mode_i | input | 2*NUM_OUT | Per-pin collision resolution code |
| down_lo_i | input | 1 | Low or unified counter is counting down |
| down_hi_i | input | 1 | High counter is counting down |
| halted_i | input | 1 | Timer halted; direct pin writes enabled |
| out_wr_i | input | 1 | Direct pin write strobe |
| out_wdata_i | input | NUM_OUT | Direct pin write value |
| conf_en_i | input | NUM_OUT | Per-pin conflict interrupt enables |
| conf_clr_i | input | NUM_OUT | Per-pin write-one-to-clear for flags |
| out_o | output | NUM_OUT | Pin values |
| conf_flag_o | output | NUM_OUT | Sticky conflict flags |
| conf_irq_o | output | 1 | Conflict interrupt |

## Verification
Several rules are checked on every cycle: a pin with no hit holds its value, a toggle collision always inverts the pin, a halted pin changes only through a direct write, a collision always leaves its flag set, and the interrupt never rises without a flag behind it. Other rules depend on a full configuration. These are the swap of set and clear for each counter direction, the exchange of resolution codes 1 and 2 under swap, and the precedence of a new collision over a clear. Only the bench scenarios can show those: directed steps first, then a long stretch of mixed random events, modes and halts, compared cycle by cycle against a model of the requirements.

// File: rtl/evres_pkg.sv
package evres_pkg;
  typedef enum logic [1:0] {
    RES_HOLD   = 2'd0,
    RES_SET    = 2'd1,
    RES_CLR    = 2'd2,
    RES_TOGGLE = 2'd3
  } res_mode_e;

  typedef enum logic [1:0] {
    SWP_NONE    = 2'd0,
    SWP_LO_DOWN = 2'd1,
    SWP_HI_DOWN = 2'd2,
    SWP_RSVD    = 2'd3
  } swap_mode_e;
endpackage

// File: rtl/evres_lane.sv
module evres_lane
  import evres_pkg::*;
#(
  parameter int NUM_EV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [NUM_EV-1:0] set_mask_i,
  input  logic [NUM_EV-1:0] clr_mask_i,
  input  logic [1:0]        swap_i,
  input  logic [1:0]        res_i,
  input  logic              down_lo_i,
  input  logic              down_hi_i,
  input  logic              halted_i,
  input  logic              wr_i,
  input  logic              wdata_i,
  output logic              out_o,
  output logic              conflict_o
);
  logic set_hit, clr_hit, swapped, nxt, out_q;

  always_comb begin
    set_hit = |(ev_i & set_mask_i);
    clr_hit = |(ev_i & clr_mask_i);
    case (swap_mode_e'(swap_i))
      SWP_LO_DOWN: swapped = down_lo_i;
      SWP_HI_DOWN: swapped = down_hi_i;
      default:     swapped = 1'b0;
    endcase
  end

  always_comb begin
    nxt = out_q;
    if (halted_i) begin
      if (wr_i) nxt = wdata_i;
    end else if (set_hit && clr_hit) begin
      case (res_mode_e'(res_i))
        RES_HOLD:   nxt = out_q;
        RES_SET:    nxt = ~swapped;
        RES_CLR:    nxt = swapped;
        RES_TOGGLE: nxt = ~out_q;
        default:    nxt = out_q;
      endcase
    end else if (set_hit) begin
      nxt = ~swapped;
    end else if (clr_hit) begin
      nxt = swapped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= nxt;
  end

  assign out_o      = out_q;
  assign conflict_o = ~halted_i & set_hit & clr_hit;

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!halted_i && !set_hit && !clr_hit) |=> $stable(out_q));

  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (!halted_i && set_hit && clr_hit && res_i == 2'd3) |=> (out_q != $past(out_q)));

  assert_halt_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (halted_i && !wr_i) |=> $stable(out_q));
endmodule

// File: rtl/evres_conflict.sv
module evres_conflict #(
  parameter int NUM_OUT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] conflict_i,
  input  logic [NUM_OUT-1:0] clr_i,
  input  logic [NUM_OUT-1:0] en_i,
  output logic [NUM_OUT-1:0] flag_o,
  output logic               irq_o
);
  logic [NUM_OUT-1:0] flag_q, flag_nxt;
  logic               irq_q;

  always_comb flag_nxt = (flag_q & ~clr_i) | conflict_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= |(flag_nxt & en_i);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (conflict_i != '0) |=> ((flag_q & $past(conflict_i)) == $past(conflict_i)));

  assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q != '0));
endmodule

// File: rtl/event_output_resolver.sv
module event_output_resolver #(
  parameter int NUM_OUT = 10,
  parameter int NUM_EV  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EV-1:0]         ev_i,
  input  logic [NUM_OUT*NUM_EV-1:0] set_mask_i,
  input  logic [NUM_OUT*NUM_EV-1:0] clr_mask_i,
  input  logic [2*NUM_OUT-1:0]      swap_mode_i,
  input  logic [2*NUM_OUT-1:0]      res_mode_i,
  input  logic                      down_lo_i,
  input  logic                      down_hi_i,
  input  logic                      halted_i,
  input  logic                      out_wr_i,
  input  logic [NUM_OUT-1:0]        out_wdata_i,
  input  logic [NUM_OUT-1:0]        conf_en_i,
  input  logic [NUM_OUT-1:0]        conf_clr_i,
  output logic [NUM_OUT-1:0]        out_o,
  output logic [NUM_OUT-1:0]        conf_flag_o,
  output logic                      conf_irq_o
);
  localparam int MODE_W = 2;

  logic [NUM_OUT-1:0] conflict;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
    evres_lane #(.NUM_EV(NUM_EV)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .ev_i       (ev_i),
      .set_mask_i (set_mask_i[n*NUM_EV +: NUM_EV]),
      .clr_mask_i (clr_mask_i[n*NUM_EV +: NUM_EV]),
      .swap_i     (swap_mode_i[n*MODE_W +: MODE_W]),
      .res_i      (res_mode_i[n*MODE_W +: MODE_W]),
      .down_lo_i  (down_lo_i),
      .down_hi_i  (down_hi_i),
      .halted_i   (halted_i),
      .wr_i       (out_wr_i),
      .wdata_i    (out_wdata_i[n]),
      .out_o      (out_o[n]),
      .conflict_o (conflict[n])
    );
  end

  evres_conflict #(.NUM_OUT(NUM_OUT)) u_conflict (
    .clk        (clk),
    .rst        (rst),
    .conflict_i (conflict),
    .clr_i      (conf_clr_i),
    .en_i       (conf_en_i),
    .flag_o     (conf_flag_o),
    .irq_o      (conf_irq_o)
  );

  assert_halt_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
    halted_i |=> ((conf_flag_o & ~$past(conf_flag_o)) == '0));
endmodule

// File: tb/event_output_resolver_tb.sv
`timescale 1ns/1ps
module event_output_resolver_tb;
  localparam int NO = 10;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic [NE-1:0]    ev;
  logic [NO*NE-1:0] smask, cmask;
  logic [2*NO-1:0]  swap, res;
  logic             dlo, dhi, halted, wr;
  logic [NO-1:0]    wdata, en, fclr;
  logic [NO-1:0]    out, flags;
  logic             irq;

  event_output_resolver #(.NUM_OUT(NO), .NUM_EV(NE)) u_dut (
    .clk(clk), .rst(rst), .ev_i(ev), .set_mask_i(smask), .clr_mask_i(cmask),
    .swap_mode_i(swap), .res_mode_i(res), .down_lo_i(dlo), .down_hi_i(dhi),
    .halted_i(halted), .out_wr_i(wr), .out_wdata_i(wdata), .conf_en_i(en),
    .conf_clr_i(fclr), .out_o(out), .conf_flag_o(flags), .conf_irq_o(irq)
  );

  typedef struct {
    logic [NO-1:0] o;
    logic [NO-1:0] f;
    logic          i;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            checks = 0;
  int            fails  = 0;
  logic [NO-1:0] m_out, m_fl;

  // Model of the requirements: next pins, flags and interrupt
  task automatic step(input string tag);
    exp_t e;
    logic [NO-1:0] nxt, conf;
    nxt  = m_out;
    conf = '0;
    for (int n = 0; n < NO; n++) begin
      logic s, c, sw;
      s  = |(ev & smask[n*NE +: NE]);
      c  = |(ev & cmask[n*NE +: NE]);
      sw = (swap[2*n +: 2] == 2'd1 && dlo) || (swap[2*n +: 2] == 2'd2 && dhi);
      if (halted) begin
        if (wr) nxt[n] = wdata[n];
      end else if (s && c) begin
        conf[n] = 1'b1;
        case (res[2*n +: 2])
          2'd1: nxt[n] = !sw;
          2'd2: nxt[n] = sw;
          2'd3: nxt[n] = !m_out[n];
          default: nxt[n] = m_out[n];
        endcase
      end else if (s) nxt[n] = !sw;
      else if (c) nxt[n] = sw;
    end
    m_out = nxt;
    m_fl  = (m_fl & ~fclr) | conf;
    e.o = m_out; e.f = m_fl; e.i = |(m_fl & en); e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expectations after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (out !== e.o || flags !== e.f || irq !== e.i) begin
        fails++;
        $display("FAIL %s: out=%h flags=%h irq=%b expected out=%h flags=%h irq=%b",
                 e.tag, out, flags, irq, e.o, e.f, e.i);
      end
    end
  end

  task automatic idle_inputs();
    ev = '0; wr = 1'b0; wdata = '0; fclr = '0; halted = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int n = 0; n < NO; n++) begin
      smask[n*NE +: NE] = NE'(1) << n;
      cmask[n*NE +: NE] = NE'(1) << (n + 6);
    end
    swap = '0; res = '0; dlo = 1'b0; dhi = 1'b0; en = '0;
    idle_inputs();
    m_out = '0; m_fl = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out !== '0 || flags !== '0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: out=%h flags=%h irq=%b expected 0 0 0", out, flags, irq);
    end

    ev = 16'h03FF;            step("R2 set via high masks");
    ev = '0;                  step("R3 hold with no events");
    ev = 16'h0F00;            step("R2 clear via low masks");
    ev = 16'hFFC0;            step("R6 hold on collision, R8 flags");
    fclr = '1; en = '1; ev = '0; step("R8 clear flags, R9 irq low");
    fclr = '0;
    ev = 16'h03FF;            step("R2 set all again");
    swap = {NO{2'd1}}; dlo = 1'b1;
    ev = 16'h003F;            step("R4 high mask clears while low counter down");
    swap = {NO{2'd2}};
    ev = 16'h003F;            step("R5 code 2 ignores low counter direction");
    dhi = 1'b1;
    ev = 16'h0040;            step("R5 code 2 swaps while high counter down");
    swap = {NO{2'd3}};
    ev = 16'h0FC0;            step("R5 code 3 never swaps");
    swap = '0; res = {NO{2'd3}};
    ev = 16'h03CF;            step("R6 toggle on collision, R9 irq");
    res = {NO{2'd1}};
    ev = 16'h03CF;            step("R6 code 1 drives high");
    res = {NO{2'd2}};
    ev = 16'h03CF;            step("R6 code 2 drives low");
    swap = {NO{2'd1}}; dlo = 1'b1; res = {NO{2'd1}};
    ev = 16'h03CF;            step("R7 code 1 drives low under swap");
    res = {NO{2'd2}};
    ev = 16'h03CF;            step("R7 code 2 drives high under swap");
    fclr = '1; ev = 16'h0041; step("R8 new collision beats clear");
    fclr = '0; swap = '0; ev = '0;
    halted = 1'b1; ev = 16'hFFFF; step("R10 events ignored while halted");
    ev = '0; wr = 1'b1; wdata = 10'h2AA; step("R10 direct write while halted");
    halted = 1'b0; wdata = 10'h155;      step("R10 write ignored while running");
    wr = 1'b0; en = 10'h001; fclr = 10'h3FE; step("R9 irq follows enabled flag");

    for (int k = 0; k < 400; k++) begin
      ev     = NE'($urandom & $urandom);
      swap   = 2*NO'($urandom);
      res    = 2*NO'($urandom);
      dlo    = 1'($urandom);
      dhi    = 1'($urandom);
      halted = ($urandom % 6) == 0;
      wr     = 1'($urandom);
      wdata  = NO'($urandom);
      en     = NO'($urandom);
      fclr   = NO'($urandom & $urandom);
      if (k % 50 == 0)
        for (int n = 0; n < NO; n++) begin
          smask[n*NE +: NE] = NE'($urandom & $urandom);
          cmask[n*NE +: NE] = NE'($urandom & $urandom);
        end
      step("R2-mix random R6 R7 R8 R9 R10");
    end
    idle_inputs();
    @(negedge clk);
    finish_run();
  end
endmodule